// File: doc/BRIEF.md
# Message-Signalled Interrupt Controller

This block gathers a small set of level-sensitive interrupt inputs and turns each new unmasked rising edge into one 32-bit memory write request. Software sees eight word registers over a simple register bus. Through them it can read the live input levels, program a mask and a per-input route, read and clear the sticky pending bits, program two write targets, and read two derived request views. When an unmasked input rises, the block places a write request on a valid/ready port. A bus master outside the block carries out the write. The route bit of that input picks which target register the request uses. That single register supplies both parts of the request: the address is the target with its five low bits cleared, and the payload is those five low bits.

Edges are detected against a registered copy of the inputs. An edge that arrives while earlier requests are still waiting joins a queue held as one bit per input. The queue drains one request per accepted handshake, lowest input index first. The block also contains a small combinational helper that maps a PCI device slot to the interrupt line it drives, using slot modulo 4.

The default configuration has eleven inputs:
- bits 0 to 5 are PCI lines A to F
- bit 6 is an external interrupt
- bit 7 is a non-fatal bus error
- bit 8 is a keyboard/mouse port
- bit 9 is unused
- bit 10 is a serial port

Top module: `msi_irq_ctrl`

## Requirements
- R1: After reset, the register selects read as follows: level (0) = 0, mask (1) = 0, route (2) = 0, pending (3) = 0, target 0 (4) = 0xFFFB0003, target 1 (5) = 0xFFFB0003, request view 0 (6) = 0, request view 1 (7) = 0. reqValid is low after reset.
- R2: The level register (select 0) shows irqIn as sampled at the previous clock edge. Writes to it have no effect.
- R3: A 0-to-1 change on input n sets pending bit n (select 3), whatever the mask. The bit stays set after the input falls.
- R4: A read of select 3 returns the pending value and clears the register at that clock edge. A write of any data to select 3 also clears it. An edge seen in the same cycle as such a clear still leaves its bit set.
- R5: Select 6 reads level AND mask AND NOT route. Select 7 reads level AND mask AND route. Writes to either have no effect.
- R6: An input that rises while its mask bit (select 1) is set produces exactly one write request. A rise on a masked input produces none.
- R7: A request for input n uses target 1 (select 5) if route bit n (select 2) is 1, and target 0 (select 4) otherwise. reqAddr is the target with bits 4:0 cleared. reqData is the target's bits 4:0, zero-extended.
- R8: Edges waiting together are issued in increasing input index, one per handshake.
- R9: Once reqValid is high, it stays high, and reqAddr and reqData stay unchanged, until a cycle with reqReady high. The transfer completes at that cycle's clock edge.
- R10: pciLine equals pciSlot modulo 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqIn | input | 11 | Level-sensitive interrupt inputs, synchronous to clk |
| regSel | input | 3 | Register select for the current access |
| regWr | input | 1 | Write strobe |
| regRd | input | 1 | Read strobe; a read of pending clears it |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for the selected register, combinational |
| reqValid | output | 1 | Write request present |
| reqReady | input | 1 | Request accepted by the bus master |
| reqAddr | output | 32 | Write address of the request |
| reqData | output | 32 | Write payload of the request |
| pciSlot | input | 5 | PCI device slot number |
| pciLine | output | 2 | Interrupt line for that slot |

## Verification
The embedded assertions check the following properties on every cycle:
- pending bits only drop when a clear strobe occurs
- a clear leaves only that cycle's new edges set
- every armed edge lands in the queue
- a request appears only while the queue holds work
- a stalled request keeps its valid, address and payload

Only the bench's scenarios can show the correct choice and content of requests:
- the mask filtering edges
- the route choosing between the two targets
- the address and payload split
- lowest-index-first draining
- the register read values, including the clear-on-read ordering against a same-cycle edge

// File: rtl/msi_irq_pkg.sv
package msi_irq_pkg;
  localparam int REG_W = 32;
  localparam int SEL_W = 3;
  localparam logic [REG_W-1:0] TGT_RESET = 32'hFFFB_0003;

  typedef enum logic [SEL_W-1:0] {
    SEL_LEVEL = 3'd0,
    SEL_MASK  = 3'd1,
    SEL_ROUTE = 3'd2,
    SEL_PEND  = 3'd3,
    SEL_TGT0  = 3'd4,
    SEL_TGT1  = 3'd5,
    SEL_REQ0  = 3'd6,
    SEL_REQ1  = 3'd7
  } regSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadReq;
    logic useTgt1;
    logic clrPend;
    logic wrMask;
    logic wrRoute;
    logic wrTgt0;
    logic wrTgt1;
  } ctlStrb_t;
endpackage

// File: rtl/msi_irq_dp.sv
module msi_irq_dp
  import msi_irq_pkg::*;
#(
  parameter int NUM_IRQ  = 11,
  parameter int ADDR_LSB = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_IRQ-1:0] irqIn,
  input  logic [SEL_W-1:0]   regSel,
  input  logic [REG_W-1:0]   regWdata,
  input  ctlStrb_t           strb,
  output logic [NUM_IRQ-1:0] riseArm,
  output logic [NUM_IRQ-1:0] routeVec,
  output logic [REG_W-1:0]   regRdata,
  output logic [REG_W-1:0]   reqAddr,
  output logic [REG_W-1:0]   reqData
);
  localparam logic [REG_W-1:0] LOW_MASK = (REG_W'(1) << ADDR_LSB) - REG_W'(1);

  logic [NUM_IRQ-1:0] levelQ, maskQ, routeQ, pendQ;
  logic [NUM_IRQ-1:0] riseVec;
  logic [REG_W-1:0]   tgt0Q, tgt1Q, tgtSel;
  logic [REG_W-1:0]   reqAddrQ, reqDataQ;

  assign riseVec  = irqIn & ~levelQ;
  assign riseArm  = riseVec & maskQ;
  assign routeVec = routeQ;
  assign tgtSel   = strb.useTgt1 ? tgt1Q : tgt0Q;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      levelQ   <= '0;
      maskQ    <= '0;
      routeQ   <= '0;
      pendQ    <= '0;
      tgt0Q    <= TGT_RESET;
      tgt1Q    <= TGT_RESET;
      reqAddrQ <= '0;
      reqDataQ <= '0;
    end else begin
      levelQ <= irqIn;
      pendQ  <= (strb.clrPend ? '0 : pendQ) | riseVec;
      if (strb.wrMask)  maskQ  <= regWdata[NUM_IRQ-1:0];
      if (strb.wrRoute) routeQ <= regWdata[NUM_IRQ-1:0];
      if (strb.wrTgt0)  tgt0Q  <= regWdata;
      if (strb.wrTgt1)  tgt1Q  <= regWdata;
      if (strb.loadReq) begin
        reqAddrQ <= tgtSel & ~LOW_MASK;
        reqDataQ <= tgtSel & LOW_MASK;
      end
    end
  end

  always_comb begin
    regRdata = '0;
    unique case (regSel_e'(regSel))
      SEL_LEVEL: regRdata[NUM_IRQ-1:0] = levelQ;
      SEL_MASK:  regRdata[NUM_IRQ-1:0] = maskQ;
      SEL_ROUTE: regRdata[NUM_IRQ-1:0] = routeQ;
      SEL_PEND:  regRdata[NUM_IRQ-1:0] = pendQ;
      SEL_TGT0:  regRdata = tgt0Q;
      SEL_TGT1:  regRdata = tgt1Q;
      SEL_REQ0:  regRdata[NUM_IRQ-1:0] = levelQ & maskQ & ~routeQ;
      SEL_REQ1:  regRdata[NUM_IRQ-1:0] = levelQ & maskQ & routeQ;
      default:   regRdata = '0;
    endcase
  end

  assign reqAddr = reqAddrQ;
  assign reqData = reqDataQ;

  // R3
  pend_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.clrPend |=> (pendQ & $past(pendQ)) == $past(pendQ));

  // R3
  pend_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|riseVec) |=> (pendQ & $past(riseVec)) == $past(riseVec));

  // R4
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrPend |=> (pendQ & ~$past(riseVec)) == '0);
endmodule

// File: rtl/msi_irq_ctl.sv
module msi_irq_ctl
  import msi_irq_pkg::*;
#(
  parameter int NUM_IRQ = 11
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [SEL_W-1:0]   regSel,
  input  logic               regWr,
  input  logic               regRd,
  input  logic [NUM_IRQ-1:0] riseArm,
  input  logic [NUM_IRQ-1:0] routeVec,
  input  logic               reqReady,
  output ctlStrb_t           strb,
  output logic               reqValid
);
  logic [NUM_IRQ-1:0] queueQ, pick, grant;
  logic               validQ, loadReq;
  regSel_e            selE;

  assign selE    = regSel_e'(regSel);
  // lowest waiting input wins
  assign pick    = queueQ & (~queueQ + NUM_IRQ'(1));
  assign loadReq = (|queueQ) && (!validQ || reqReady);
  assign grant   = loadReq ? pick : '0;

  always_comb begin
    strb.loadReq = loadReq;
    strb.useTgt1 = |(pick & routeVec);
    strb.clrPend = (regWr || regRd) && (selE == SEL_PEND);
    strb.wrMask  = regWr && (selE == SEL_MASK);
    strb.wrRoute = regWr && (selE == SEL_ROUTE);
    strb.wrTgt0  = regWr && (selE == SEL_TGT0);
    strb.wrTgt1  = regWr && (selE == SEL_TGT1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      queueQ <= '0;
      validQ <= 1'b0;
    end else begin
      queueQ <= (queueQ & ~grant) | riseArm;
      if (loadReq)       validQ <= 1'b1;
      else if (reqReady) validQ <= 1'b0;
    end
  end

  assign reqValid = validQ;

  // R6
  arm_queue_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|riseArm) |=> (queueQ & $past(riseArm)) == $past(riseArm));

  // R6
  valid_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(validQ) |-> $past(|queueQ));

  // R9
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    validQ && !reqReady |=> validQ);
endmodule

// File: rtl/msi_irq_ctrl.sv
module msi_irq_ctrl
  import msi_irq_pkg::*;
#(
  parameter int NUM_IRQ  = 11,
  parameter int ADDR_LSB = 5,
  parameter int SLOT_W   = 5,
  parameter int LINE_W   = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_IRQ-1:0] irqIn,
  input  logic [SEL_W-1:0]   regSel,
  input  logic               regWr,
  input  logic               regRd,
  input  logic [REG_W-1:0]   regWdata,
  output logic [REG_W-1:0]   regRdata,
  output logic               reqValid,
  input  logic               reqReady,
  output logic [REG_W-1:0]   reqAddr,
  output logic [REG_W-1:0]   reqData,
  input  logic [SLOT_W-1:0]  pciSlot,
  output logic [LINE_W-1:0]  pciLine
);
  localparam int LINES = 1 << LINE_W;

  ctlStrb_t           strb;
  logic [NUM_IRQ-1:0] riseArm, routeVec;

  msi_irq_ctl #(.NUM_IRQ(NUM_IRQ)) uCtl (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWr(regWr), .regRd(regRd),
    .riseArm(riseArm), .routeVec(routeVec), .reqReady(reqReady),
    .strb(strb), .reqValid(reqValid)
  );

  msi_irq_dp #(.NUM_IRQ(NUM_IRQ), .ADDR_LSB(ADDR_LSB)) uDp (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .regSel(regSel),
    .regWdata(regWdata), .strb(strb), .riseArm(riseArm),
    .routeVec(routeVec), .regRdata(regRdata), .reqAddr(reqAddr),
    .reqData(reqData)
  );

  assign pciLine = LINE_W'(pciSlot % SLOT_W'(LINES));

  // R9
  req_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqReady |=> $stable(reqAddr) && $stable(reqData));
endmodule

// File: tb/msi_irq_ctrl_test.sv
module msi_irq_ctrl_test;
  import msi_irq_pkg::*;

  localparam logic [31:0] T0 = 32'h1234_5687;
  localparam logic [31:0] T1 = 32'hABCD_EF3F;

  logic        clk = 1'b0;
  logic        rstN, regWr, regRd, reqValid, reqReady;
  logic [10:0] irqIn;
  logic [2:0]  regSel;
  logic [31:0] regWdata, regRdata, reqAddr, reqData, rd;
  logic [4:0]  pciSlot;
  logic [1:0]  pciLine;
  int          total = 0, bad = 0;
  logic [63:0] expQ[$];

  always #2 clk = ~clk;

  msi_irq_ctrl uut (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .regSel(regSel), .regWr(regWr),
    .regRd(regRd), .regWdata(regWdata), .regRdata(regRdata),
    .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr),
    .reqData(reqData), .pciSlot(pciSlot), .pciLine(pciLine)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); regSel = a; regWdata = d; regWr = 1'b1;
    @(posedge clk); #1 regWr = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); regSel = a; regRd = 1'b1;
    #1 d = regRdata;
    @(posedge clk); #1 regRd = 1'b0;
  endtask

  task automatic readChk(input string req, input logic [2:0] a, input logic [31:0] exp);
    logic [31:0] v;
    regRead(a, v);
    chk(req, v, exp);
  endtask

  task automatic expectReq(input logic [31:0] tgt);
    expQ.push_back({tgt & ~32'h1F, tgt & 32'h1F});
  endtask

  task automatic setIrq(input logic [10:0] v);
    @(negedge clk); irqIn = v;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: compare each handshake against the scoreboard
  always @(negedge clk) begin
    #1;
    if (rstN === 1'b1 && reqValid && reqReady) begin
      if (expQ.size() == 0) begin
        total++; bad++;
        $display("FAIL R6 unexpected request actual=%h/%h expected=none", reqAddr, reqData);
      end else begin
        logic [63:0] e;
        e = expQ.pop_front();
        chk("R7/R8 request address", reqAddr, e[63:32]);
        chk("R7/R8 request data", reqData, e[31:0]);
      end
    end
  end

  initial begin
    #(4 * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rstN = 1'b0; irqIn = '0; regSel = '0; regWr = 1'b0; regRd = 1'b0;
    regWdata = '0; reqReady = 1'b0; pciSlot = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1 reset state
    chk("R1 reqValid", {31'b0, reqValid}, 32'h0);
    readChk("R1 level", SEL_LEVEL, 32'h0);
    readChk("R1 mask", SEL_MASK, 32'h0);
    readChk("R1 route", SEL_ROUTE, 32'h0);
    readChk("R1 pending", SEL_PEND, 32'h0);
    readChk("R1 target0", SEL_TGT0, 32'hFFFB_0003);
    readChk("R1 target1", SEL_TGT1, 32'hFFFB_0003);
    readChk("R1 req view0", SEL_REQ0, 32'h0);
    readChk("R1 req view1", SEL_REQ1, 32'h0);

    regWrite(SEL_TGT0, T0);
    regWrite(SEL_TGT1, T1);
    regWrite(SEL_MASK, 32'h7FF);
    regWrite(SEL_ROUTE, 32'h0F0);
    @(negedge clk) reqReady = 1'b1;

    // R2 / R3 / R4 basic
    expectReq(T0);
    setIrq(11'h004);
    waitCyc(3);
    readChk("R2 level follows input", SEL_LEVEL, 32'h004);
    readChk("R3 pending set", SEL_PEND, 32'h004);
    readChk("R4 pending cleared by read", SEL_PEND, 32'h0);
    regWrite(SEL_LEVEL, 32'h7FF);
    readChk("R2 level write ignored", SEL_LEVEL, 32'h004);

    expectReq(T0);
    setIrq(11'h00C);
    waitCyc(2);
    setIrq(11'h004);
    waitCyc(2);
    readChk("R3 pending sticky after fall", SEL_PEND, 32'h008);

    expectReq(T0);
    setIrq(11'h006);
    waitCyc(2);
    regWrite(SEL_PEND, 32'h0);
    readChk("R4 pending cleared by write", SEL_PEND, 32'h0);

    // R5 request views; bit5 routes to target 1 (R7)
    expectReq(T1);
    setIrq(11'h026);
    waitCyc(3);
    readChk("R5 view0", SEL_REQ0, 32'h006);
    readChk("R5 view1", SEL_REQ1, 32'h020);
    regWrite(SEL_MASK, 32'h7FD);
    readChk("R5 view0 after mask", SEL_REQ0, 32'h004);
    regWrite(SEL_REQ0, 32'hFFFF_FFFF);
    readChk("R5 view0 write ignored", SEL_REQ0, 32'h004);
    readChk("R5 view1 unchanged", SEL_REQ1, 32'h020);

    // R6 masked edge gives no request but still pends
    setIrq(11'h024);
    waitCyc(2);
    regRead(SEL_PEND, rd);
    setIrq(11'h026);
    waitCyc(4);
    chk("R6 masked edge no request", {31'b0, reqValid}, 32'h0);
    readChk("R3 masked edge pends", SEL_PEND, 32'h002);

    // R8 / R9 simultaneous edges under back-pressure
    @(negedge clk) reqReady = 1'b0;
    setIrq(11'h000);
    waitCyc(2);
    expectReq(T0); expectReq(T1); expectReq(T1); expectReq(T0);
    setIrq(11'h451);
    waitCyc(4);
    chk("R9 valid while stalled", {31'b0, reqValid}, 32'h1);
    chk("R8 lowest first addr", reqAddr, 32'h1234_5680);
    waitCyc(3);
    chk("R9 valid held", {31'b0, reqValid}, 32'h1);
    chk("R9 data held", reqData, 32'h7);
    @(negedge clk) reqReady = 1'b1;
    waitCyc(10);
    chk("R8 queue drained", 32'(expQ.size()), 32'h0);

    // R4 read clear and edge in the same cycle
    setIrq(11'h000);
    waitCyc(2);
    regRead(SEL_PEND, rd);
    expectReq(T1);
    @(negedge clk); irqIn = 11'h080; regSel = SEL_PEND; regRd = 1'b1;
    #1 rd = regRdata;
    @(posedge clk); #1 regRd = 1'b0;
    chk("R4 read returns old value", rd, 32'h0);
    waitCyc(1);
    readChk("R4 same-cycle edge kept", SEL_PEND, 32'h080);

    // R10 slot to line
    for (int s = 0; s < 32; s++) begin
      pciSlot = s[4:0];
      #1 chk("R10 slot line", {30'b0, pciLine}, 32'(s % 4));
    end

    waitCyc(5);
    chk("R6 all expected requests issued", 32'(expQ.size()), 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule